// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block is the interrupt-identification logic that sits beside a UART's receiver, transmitter and modem-signal inputs. It keeps the pending state of five interrupt sources (receiver line errors, received data available, character timeout, transmit holding register empty and modem signal changes). It masks each source with an enable register and picks the most urgent enabled source. It presents the result as an eight-bit identification byte and a single interrupt request line.

The surrounding register file feeds it event pulses and levels, the FIFO-mode flag, and one-cycle strobes for reads of the line-status, modem-status and receive registers and writes of the transmit register. The identification read is a level that stays high for as long as the bus access lasts. The block also holds the four modem change flags that the modem-status register shows, and the enable register with its readback value. Inputs are sampled on the rising clock edge. A pending state changes one edge after its cause, and the identification byte and request line follow on the next edge.

Top module: `uart_irq_ident`

## Requirements
- R1: Among enabled pending sources the reported one is chosen in this order: line error first, then received data, then character timeout, then transmit holding empty, then modem change.
- R2: Bit 0 of the identification byte is 0 while an enabled source is pending and 1 otherwise. `irq` is 1 exactly when an enabled source is pending.
- R3: Bits 3:1 carry the source code: line error 011, received data 010, timeout 110, transmit empty 001, modem change 000.
- R4: Bits 7:6 read 11 while `fifo_en` is 1 and 00 otherwise. Bits 5:4 are 0. The timeout source, and so bit 3, can only be pending in FIFO mode.
- R5: A transmit-empty condition is cleared by `thr_wr`. It is also cleared at the end of an identification read, but only if that read returned the transmit-empty code (low nibble 0x2).
- R6: While `iir_rd` is high, and for the cycle after it falls, `iir_q` is held. Events during the read are kept and reported once the hold ends.
- R7: `msr_delta` bits [0] CTS, [1] DSR and [3] DCD set on any change of their pin. Bit [2] sets only on a 0-to-1 change of `ri_pin`. `msr_rd` clears all four, and a new change in the same cycle wins.
- R8: `ier_q` bits 0..3 enable received data and timeout, transmit empty, line error and modem change, in that order, and bits 7:4 read 0. A disabled source neither raises `irq` nor appears in the identification byte.
- R9: A line error stays pending until `lsr_rd`. A timeout stays pending until `rbr_rd` or until FIFO mode is left. Received data follows the `rx_avail` level.
- R10: Transmit empty becomes pending on a rising edge of `thr_empty`, and also when `fifo_en` rises while `thr_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode flag |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_q | output | 8 | Enable register readback |
| ls_err_evt | input | 1 | Pulse: a receiver line error was detected |
| rx_avail | input | 1 | Level: received data available / trigger reached |
| rx_tmo_evt | input | 1 | Pulse: character timeout expired |
| thr_empty | input | 1 | Level: transmit holding register empty |
| cts_pin | input | 1 | Clear-to-send level |
| dsr_pin | input | 1 | Data-set-ready level |
| dcd_pin | input | 1 | Carrier-detect level |
| ri_pin | input | 1 | Ring-indicator level |
| iir_rd | input | 1 | High for the duration of an identification read |
| lsr_rd | input | 1 | Line-status read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| rbr_rd | input | 1 | Receive register read strobe |
| thr_wr | input | 1 | Transmit register write strobe |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| msr_delta | output | 4 | Modem change flags |

## Verification
The two functions that can fall in the same cycle are the end of an identification read and a fresh set of a source. One case is a line error or received data that arrives while a read is frozen. Another is a transmit-empty rise or modem pin change in the very cycle its clearing strobe is given. The bench provokes both in directed sequences and again by random stimulus with overlapping read bursts and strobes. It judges every cycle against a behavioural model that applies "new event beats clear" and "frozen value decides the read side effect".

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  // request index, lowest index = highest priority
  localparam int SRC_LS   = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;
  // enable register bit positions
  localparam int EN_RX   = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LS   = 2;
  localparam int EN_MS   = 3;
  localparam int EN_W    = 4;
  // modem pin vector positions
  localparam int MP_CTS = 0;
  localparam int MP_DSR = 1;
  localparam int MP_RI  = 2;
  localparam int MP_DCD = 3;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_THRE  = 3'b001,
    ID_RDA   = 3'b010,
    ID_LS    = 3'b011,
    ID_TMO   = 3'b110
  } irq_id_e;

  function automatic irq_id_e src_id(input int idx);
    case (idx)
      SRC_LS:   return ID_LS;
      SRC_RDA:  return ID_RDA;
      SRC_TMO:  return ID_TMO;
      SRC_THRE: return ID_THRE;
      default:  return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [2:0]   id
);
  always_comb begin
    any = |req;
    id  = ID_MODEM;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = src_id(i);
    end
  end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int IER_W = 8,
  parameter int MS_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             ier_we,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             ls_err_evt,
  input  logic             rx_avail,
  input  logic             rx_tmo_evt,
  input  logic             thr_empty,
  input  logic [MS_W-1:0]  mdm_pins,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  input  logic             id_rd_clr,
  output logic [NSRC-1:0]  req,
  output logic [MS_W-1:0]  msr_delta,
  output logic [IER_W-1:0] ier_q
);
  localparam int HI_W = IER_W - EN_W;

  logic [EN_W-1:0] ier_r;
  logic            ls_pend, tmo_pend, thre_pend;
  logic [MS_W-1:0] pin_d, delta_set;
  logic            thr_d, fifo_d, thre_set;
  logic            ier_unused;

  assign ier_unused = ^ier_wdata[IER_W-1:EN_W];
  assign ier_q      = {{HI_W{1'b0}}, ier_r};

  // change detectors: ring indicator is edge-specific, others any change
  for (genvar g = 0; g < MS_W; g++) begin : g_delta
    if (g == MP_RI) begin : g_ri
      assign delta_set[g] = mdm_pins[g] & ~pin_d[g];
    end else begin : g_chg
      assign delta_set[g] = mdm_pins[g] ^ pin_d[g];
    end
  end

  assign thre_set = (thr_empty & ~thr_d) | (fifo_en & ~fifo_d & thr_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_r     <= '0;
      ls_pend   <= 1'b0;
      tmo_pend  <= 1'b0;
      thre_pend <= 1'b0;
      msr_delta <= '0;
      pin_d     <= mdm_pins;
      thr_d     <= thr_empty;
      fifo_d    <= fifo_en;
    end else begin
      if (ier_we) ier_r <= ier_wdata[EN_W-1:0];
      ls_pend   <= ls_err_evt | (ls_pend & ~lsr_rd);
      tmo_pend  <= fifo_en & (rx_tmo_evt | (tmo_pend & ~rbr_rd));
      thre_pend <= thre_set | (thre_pend & ~thr_wr & ~id_rd_clr);
      msr_delta <= delta_set | (msr_delta & {MS_W{~msr_rd}});
      pin_d     <= mdm_pins;
      thr_d     <= thr_empty;
      fifo_d    <= fifo_en;
    end
  end

  assign req[SRC_LS]   = ier_r[EN_LS]   & ls_pend;
  assign req[SRC_RDA]  = ier_r[EN_RX]   & rx_avail;
  assign req[SRC_TMO]  = ier_r[EN_RX]   & tmo_pend & fifo_en;
  assign req[SRC_THRE] = ier_r[EN_THRE] & thre_pend;
  assign req[SRC_MS]   = ier_r[EN_MS]   & (|msr_delta);

  // R9: a line-status read with no new error leaves nothing pending
  assert_ls_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ls_err_evt) |=> !ls_pend)
    else $error("line error survived its read");

  // R5: a transmit write with no new empty edge clears transmit-empty
  assert_thr_wr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !thre_set) |=> !thre_pend)
    else $error("transmit empty survived a write");

  // R7: a modem-status read with quiet pins leaves all change flags clear
  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && $stable(mdm_pins)) |=> (msr_delta == '0))
    else $error("modem change flag survived its read");
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IER_W = 8,
  parameter int MS_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             ier_we,
  input  logic [IER_W-1:0] ier_wdata,
  output logic [IER_W-1:0] ier_q,
  input  logic             ls_err_evt,
  input  logic             rx_avail,
  input  logic             rx_tmo_evt,
  input  logic             thr_empty,
  input  logic             cts_pin,
  input  logic             dsr_pin,
  input  logic             dcd_pin,
  input  logic             ri_pin,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  output logic [7:0]       iir_q,
  output logic             irq,
  output logic [MS_W-1:0]  msr_delta
);
  localparam logic [7:0] IIR_IDLE = 8'h01;

  logic [NSRC-1:0] req;
  logic            any;
  logic [2:0]      id;
  logic            rd_d, hold, id_rd_clr;
  logic [7:0]      iir_next;
  logic [MS_W-1:0] mdm_pins;

  always_comb begin
    mdm_pins         = '0;
    mdm_pins[MP_CTS] = cts_pin;
    mdm_pins[MP_DSR] = dsr_pin;
    mdm_pins[MP_RI]  = ri_pin;
    mdm_pins[MP_DCD] = dcd_pin;
  end

  // value frozen while the read lasts and one cycle beyond, so the
  // read side effect is decided on exactly what the bus saw
  assign hold      = iir_rd | rd_d;
  assign id_rd_clr = ~iir_rd & rd_d & (iir_q[3:0] == {ID_THRE, 1'b0});
  assign iir_next  = {fifo_en, fifo_en, 2'b00, id, ~any};

  uart_irq_sources #(.IER_W(IER_W), .MS_W(MS_W)) i_src (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .ier_we     (ier_we),
    .ier_wdata  (ier_wdata),
    .ls_err_evt (ls_err_evt),
    .rx_avail   (rx_avail),
    .rx_tmo_evt (rx_tmo_evt),
    .thr_empty  (thr_empty),
    .mdm_pins   (mdm_pins),
    .lsr_rd     (lsr_rd),
    .msr_rd     (msr_rd),
    .rbr_rd     (rbr_rd),
    .thr_wr     (thr_wr),
    .id_rd_clr  (id_rd_clr),
    .req        (req),
    .msr_delta  (msr_delta),
    .ier_q      (ier_q)
  );

  uart_irq_prio #(.N(NSRC)) i_prio (
    .req (req),
    .any (any),
    .id  (id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= IIR_IDLE;
      irq   <= 1'b0;
      rd_d  <= 1'b0;
    end else begin
      rd_d <= iir_rd;
      irq  <= any;
      if (!hold) iir_q <= iir_next;
    end
  end

  // R6: the identification byte does not move during a read or right after
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (iir_rd || rd_d) |=> $stable(iir_q))
    else $error("identification changed during a read");

  // R2: outside a hold, pending bit and request line agree
  assert_pend_irq_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(iir_rd) && !$past(rd_d)) |-> (iir_q[0] == !irq))
    else $error("pending bit and irq disagree");

  // R4: a timeout code only appears with the FIFO-mode bits set
  assert_tmo_fifo_R4: assert property (@(posedge clk) disable iff (rst)
    iir_q[3] |-> (iir_q[7:6] == 2'b11))
    else $error("timeout code outside FIFO mode");
endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, ier_we = 0;
  logic [7:0] ier_wdata = 0;
  logic ls_err_evt = 0, rx_avail = 0, rx_tmo_evt = 0, thr_empty = 0;
  logic cts_pin = 0, dsr_pin = 0, dcd_pin = 0, ri_pin = 0;
  logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, rbr_rd = 0, thr_wr = 0;
  logic [7:0] ier_q, iir_q;
  logic irq;
  logic [3:0] msr_delta;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier_we(ier_we),
    .ier_wdata(ier_wdata), .ier_q(ier_q), .ls_err_evt(ls_err_evt),
    .rx_avail(rx_avail), .rx_tmo_evt(rx_tmo_evt), .thr_empty(thr_empty),
    .cts_pin(cts_pin), .dsr_pin(dsr_pin), .dcd_pin(dcd_pin), .ri_pin(ri_pin),
    .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rbr_rd(rbr_rd),
    .thr_wr(thr_wr), .iir_q(iir_q), .irq(irq), .msr_delta(msr_delta)
  );

  // ---------------- behavioural reference model ----------------
  bit       m_valid = 0;
  bit [3:0] m_ier;
  bit       m_ls, m_tmo, m_thre, m_rdd, m_thr_d, m_fifo_d, m_irq;
  bit [3:0] m_dl, m_prev, pins_now;
  bit [7:0] m_iir;

  always @(posedge clk) begin
    bit r_ls, r_rda, r_tmo, r_thre, r_ms, anyr, clr_id, tset, setb;
    bit [2:0] code;
    pins_now = {dcd_pin, ri_pin, dsr_pin, cts_pin};
    if (rst) begin
      m_valid = 1; m_ier = 0; m_ls = 0; m_tmo = 0; m_thre = 0; m_rdd = 0;
      m_irq = 0; m_iir = 8'h01; m_dl = 0; m_prev = pins_now;
      m_thr_d = thr_empty; m_fifo_d = fifo_en;
    end else begin
      r_ls   = m_ier[2] & m_ls;
      r_rda  = m_ier[0] & rx_avail;
      r_tmo  = m_ier[0] & m_tmo & fifo_en;
      r_thre = m_ier[1] & m_thre;
      r_ms   = m_ier[3] & (m_dl != 0);
      anyr   = r_ls | r_rda | r_tmo | r_thre | r_ms;
      if (r_ls) code = 3'b011;
      else if (r_rda) code = 3'b010;
      else if (r_tmo) code = 3'b110;
      else if (r_thre) code = 3'b001;
      else code = 3'b000;
      clr_id = !iir_rd && m_rdd && (m_iir[3:0] == 4'h2);
      if (!(iir_rd || m_rdd)) m_iir = {fifo_en, fifo_en, 2'b00, code, !anyr};
      m_irq = anyr;
      m_rdd = iir_rd;
      tset = (thr_empty && !m_thr_d) || (fifo_en && !m_fifo_d && thr_empty);
      m_thre = tset || (m_thre && !thr_wr && !clr_id);
      m_ls = ls_err_evt || (m_ls && !lsr_rd);
      m_tmo = fifo_en && (rx_tmo_evt || (m_tmo && !rbr_rd));
      for (int i = 0; i < 4; i++) begin
        setb = (i == 2) ? (pins_now[i] && !m_prev[i]) : (pins_now[i] != m_prev[i]);
        m_dl[i] = setb || (m_dl[i] && !msr_rd);
      end
      m_prev = pins_now; m_thr_d = thr_empty; m_fifo_d = fifo_en;
      if (ier_we) m_ier = ier_wdata[3:0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid) begin
      chk("R3 iir_q vs model", iir_q, m_iir);
      chk("R2 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      chk("R7 msr_delta vs model", {4'd0, msr_delta}, {4'd0, m_dl});
      chk("R8 ier_q vs model", ier_q, {4'd0, m_ier});
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic ier_write(input logic [7:0] v);
    ier_wdata = v; ier_we = 1; tick(1); ier_we = 0; tick(1);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk); tick(3); rst = 0;
    chk("R2 reset idle byte", iir_q, 8'h01);
    chk("R2 reset irq", {7'd0, irq}, 8'h00);

    ier_write(8'hFF);
    chk("R8 upper enable bits read zero", ier_q, 8'h0F);

    thr_empty = 1; tick(2);
    chk("R10 transmit empty rise", iir_q, 8'h02);
    chk("R2 irq raised", {7'd0, irq}, 8'h01);

    ls_err_evt = 1; tick(1); ls_err_evt = 0; tick(1);
    chk("R1 line error above transmit empty", iir_q, 8'h06);
    lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
    chk("R9 line-status read clears", iir_q, 8'h02);

    iir_rd = 1; tick(1); rx_avail = 1; tick(2);
    chk("R6 frozen during read", iir_q, 8'h02);
    iir_rd = 0; tick(2);
    chk("R6 new event shown after read", iir_q, 8'h04);
    rx_avail = 0; tick(2);
    chk("R5 read of transmit code cleared it", iir_q, 8'h01);

    ls_err_evt = 1; tick(1); ls_err_evt = 0; tick(1);
    thr_empty = 0; tick(1); thr_empty = 1; tick(2);
    iir_rd = 1; tick(1); iir_rd = 0; tick(2);
    chk("R5 read of other code keeps line error", iir_q, 8'h06);
    lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
    chk("R5 read of other code left transmit empty", iir_q, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0; tick(1);
    chk("R5 transmit write clears", iir_q, 8'h01);

    cts_pin = 1; tick(2);
    chk("R7 cts change flag", {4'd0, msr_delta}, 8'h01);
    chk("R3 modem code", iir_q, 8'h00);
    ri_pin = 1; tick(2);
    chk("R7 ring rise flag", {4'd0, msr_delta}, 8'h05);
    msr_rd = 1; tick(1); msr_rd = 0; tick(1);
    chk("R7 modem read clears", {4'd0, msr_delta}, 8'h00);
    ri_pin = 0; tick(2);
    chk("R7 ring fall ignored", {4'd0, msr_delta}, 8'h00);
    chk("R7 no modem interrupt", iir_q, 8'h01);

    fifo_en = 1; tick(2);
    chk("R10 fifo enable raises transmit empty", iir_q, 8'hC2);
    rx_tmo_evt = 1; tick(1); rx_tmo_evt = 0; tick(1);
    chk("R4 timeout code with fifo bits", iir_q, 8'hCC);
    rx_avail = 1; tick(2);
    chk("R1 data available above timeout", iir_q, 8'hC4);
    rx_avail = 0; tick(2);
    chk("R3 timeout back", iir_q, 8'hCC);
    rbr_rd = 1; tick(1); rbr_rd = 0; tick(1);
    chk("R9 receive read clears timeout", iir_q, 8'hC2);
    thr_wr = 1; tick(1); thr_wr = 0; tick(1);
    chk("R4 fifo idle byte", iir_q, 8'hC1);

    ier_write(8'h00);
    ls_err_evt = 1; tick(1); ls_err_evt = 0; tick(1);
    chk("R8 disabled source hidden", iir_q, 8'hC1);
    chk("R8 disabled source no irq", {7'd0, irq}, 8'h00);
    lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
    ier_write(8'h0F);

    // random overlap of events, strobes and read bursts
    for (int n = 0; n < 4000; n++) begin
      ls_err_evt = ($urandom_range(0, 15) == 0);
      rx_tmo_evt = ($urandom_range(0, 15) == 0);
      lsr_rd = ($urandom_range(0, 7) == 0);
      msr_rd = ($urandom_range(0, 7) == 0);
      rbr_rd = ($urandom_range(0, 7) == 0);
      thr_wr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) rx_avail = ~rx_avail;
      if ($urandom_range(0, 4) == 0) thr_empty = ~thr_empty;
      if ($urandom_range(0, 9) == 0) cts_pin = ~cts_pin;
      if ($urandom_range(0, 9) == 0) dsr_pin = ~dsr_pin;
      if ($urandom_range(0, 9) == 0) dcd_pin = ~dcd_pin;
      if ($urandom_range(0, 7) == 0) ri_pin = ~ri_pin;
      if ($urandom_range(0, 60) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 3) == 0) iir_rd = ~iir_rd;
      ier_we = ($urandom_range(0, 40) == 0);
      ier_wdata = 8'($urandom);
      tick(1);
    end
    {ls_err_evt, rx_tmo_evt, lsr_rd, msr_rd, rbr_rd, thr_wr, iir_rd, ier_we} = '0;
    tick(3);
    summary();
  end
endmodule